// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the clock and data lines of a two-wire I2C bus and never drives either of them. It has no output pins toward the bus, so it cannot acknowledge or stretch the clock. Both lines pass through a synchronizer into the system clock domain. The block then finds bus conditions and frames the traffic into bytes, whatever address the bytes carry.

Each finding becomes an 11-bit record on a valid/ready stream. The record holds a kind, a data byte and an acknowledge bit, and downstream logic can log it. A small FIFO absorbs stalls on the stream. If a record arrives while the FIFO is full, the record is dropped and a sticky overflow flag is set. The flag stays set until a clear pulse.

A separate trigger output samples the clock level on every falling edge of the data line. When it finds a start, it gives a clean pulse whose rising edge can arm an instrument.

Top module: `i2c_bus_watcher`

## Requirements
- R1: SDA falling while SCL is high, with no transfer open, emits a record of kind 2'b00 with data 8'h00 and ack 0, and opens a transfer.
- R2: SDA falling while SCL is high with a transfer already open emits a record of kind 2'b01 (repeated start) with data 8'h00 and ack 0.
- R3: SDA rising while SCL is high emits a record of kind 2'b10 and closes the transfer. SCL pulses after it, with no new start, emit nothing.
- R4: Inside an open transfer, eight SCL rising edges shift SDA in with the most significant bit first. The ninth rising edge samples SDA as the ack bit (0 = acknowledged). A record of kind 2'b11 then carries the byte and that bit, for any address value.
- R5: A start or repeated start in the middle of a byte discards the bits gathered so far. Framing of the next byte begins from bit zero.
- R6: trig_out rises once for each start or repeated start, stays high for exactly TRIG_HOLD system clocks, and is otherwise low.
- R7: While evt_ready is low, up to DEPTH records are held. evt_valid and the record fields stay stable until accepted, and records leave in the order they were made.
- R8: A record made while the FIFO holds DEPTH entries and none leaves is dropped and sets ovf_flag. The flag stays set until ovf_clear is pulsed.
- R9: After reset, evt_valid, trig_out and ovf_flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Observed bus clock line |
| sda_i | input | 1 | Observed bus data line |
| evt_valid | output | 1 | A record is offered |
| evt_ready | input | 1 | Downstream accepts the record |
| evt_kind | output | 2 | 00 start, 01 repeated start, 10 stop, 11 byte |
| evt_data | output | 8 | Byte value, zero for non-byte records |
| evt_ack | output | 1 | SDA level on the ninth clock |
| trig_out | output | 1 | Start trigger pulse |
| ovf_flag | output | 1 | Sticky record-drop flag |
| ovf_clear | input | 1 | Clears ovf_flag |

## Verification
Assertions check several properties on every cycle: the bit counter stays in range, a stop record always leaves the transfer closed, the trigger does not collapse to a single cycle, a stalled record stays stable, and the overflow flag stays sticky and is set on a drop. Other behaviour needs bus scenarios built by the bench: the correct kind for each start, MSB-first byte values with their ack levels, a partial byte being discarded, clock pulses ignored after a stop, and which records survive an overflow. The bench compares every record against its own model of the traffic.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    typedef enum logic [1:0] {
        EV_START  = 2'b00,
        EV_RSTART = 2'b01,
        EV_STOP   = 2'b10,
        EV_BYTE   = 2'b11
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e   kind;
        logic [7:0] data;
        logic       ack;
    } ev_rec_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] now,
    output logic [LINES-1:0] prev
);
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            logic [STAGES:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-1:0], raw[i]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= chain_d;
            end

            assign now[i]  = chain_q[STAGES-1];
            assign prev[i] = chain_q[STAGES];
        end
    endgenerate
endmodule

// File: rtl/i2cw_framer.sv
module i2cw_framer
    import i2cw_pkg::*;
#(
    parameter int TRIG_HOLD = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_now,
    input  logic    scl_prev,
    input  logic    sda_now,
    input  logic    sda_prev,
    output logic    ev_valid,
    output ev_rec_t ev_rec,
    output logic    trig
);
    localparam int TW = $clog2(TRIG_HOLD + 1);

    typedef struct packed {
        logic          active;
        logic [3:0]    cnt;
        logic [7:0]    shreg;
        logic          ev_valid;
        ev_rec_t       ev;
        logic [TW-1:0] trig_cnt;
    } frm_t;

    frm_t st_d, st_q;

    logic scl_high, is_start, is_stop, scl_rise;

    always_comb begin
        scl_high = scl_now && scl_prev;
        is_start = scl_high && sda_prev && !sda_now;
        is_stop  = scl_high && !sda_prev && sda_now;
        scl_rise = scl_now && !scl_prev;

        st_d          = st_q;
        st_d.ev_valid = 1'b0;
        if (st_q.trig_cnt != '0) st_d.trig_cnt = st_q.trig_cnt - 1'b1;

        if (is_start) begin
            st_d.ev_valid = 1'b1;
            st_d.ev.kind  = st_q.active ? EV_RSTART : EV_START;
            st_d.ev.data  = 8'h00;
            st_d.ev.ack   = 1'b0;
            st_d.active   = 1'b1;
            st_d.cnt      = '0;
            st_d.shreg    = '0;
            st_d.trig_cnt = TW'(TRIG_HOLD);
        end else if (is_stop) begin
            st_d.ev_valid = 1'b1;
            st_d.ev.kind  = EV_STOP;
            st_d.ev.data  = 8'h00;
            st_d.ev.ack   = 1'b0;
            st_d.active   = 1'b0;
            st_d.cnt      = '0;
        end else if (scl_rise && st_q.active) begin
            if (st_q.cnt == 4'd8) begin
                st_d.ev_valid = 1'b1;
                st_d.ev.kind  = EV_BYTE;
                st_d.ev.data  = st_q.shreg;
                st_d.ev.ack   = sda_now;
                st_d.cnt      = '0;
            end else begin
                st_d.shreg = {st_q.shreg[6:0], sda_now};
                st_d.cnt   = st_q.cnt + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_valid = st_q.ev_valid;
    assign ev_rec   = st_q.ev;
    assign trig     = (st_q.trig_cnt != '0);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= 4'd8);

    p_stop_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ev_valid && st_q.ev.kind == EV_STOP) |-> !st_q.active);

    generate
        if (TRIG_HOLD >= 2) begin : g_trig_chk
            p_trig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(trig) |=> trig);
        end
    endgenerate
endmodule

// File: rtl/i2cw_fifo.sv
module i2cw_fifo
    import i2cw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  ev_rec_t in_rec,
    output logic    out_valid,
    input  logic    out_ready,
    output ev_rec_t out_rec,
    output logic    ovf,
    input  logic    ovf_clear
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        ev_rec_t [DEPTH-1:0] mem;
        logic [AW-1:0]       wr;
        logic [AW-1:0]       rd;
        logic [CW-1:0]       count;
        logic                ovf;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  pop, push_ok, full;

    always_comb begin
        full    = (st_q.count == CW'(DEPTH));
        pop     = (st_q.count != '0) && out_ready;
        push_ok = in_valid && (!full || pop);

        st_d = st_q;
        if (ovf_clear) st_d.ovf = 1'b0;
        if (pop) st_d.rd = st_q.rd + 1'b1;
        if (push_ok) begin
            st_d.mem[st_q.wr] = in_rec;
            st_d.wr           = st_q.wr + 1'b1;
        end else if (in_valid) begin
            st_d.ovf = 1'b1;
        end
        st_d.count = st_q.count + CW'(push_ok) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = (st_q.count != '0);
    assign out_rec   = st_q.mem[st_q.rd];
    assign ovf       = st_q.ovf;

    p_valid_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clear) |=> ovf);

    p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && full && !out_ready) |=> ovf);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));
endmodule

// File: rtl/i2c_bus_watcher.sv
module i2c_bus_watcher
    import i2cw_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int TRIG_HOLD   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       evt_valid,
    input  logic       evt_ready,
    output logic [1:0] evt_kind,
    output logic [7:0] evt_data,
    output logic       evt_ack,
    output logic       trig_out,
    output logic       ovf_flag,
    input  logic       ovf_clear
);
    logic [1:0] line_now, line_prev;
    logic       fr_valid;
    ev_rec_t    fr_rec, q_rec;

    i2cw_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({scl_i, sda_i}),
        .now  (line_now),
        .prev (line_prev)
    );

    i2cw_framer #(.TRIG_HOLD(TRIG_HOLD)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_now (line_now[1]),
        .scl_prev(line_prev[1]),
        .sda_now (line_now[0]),
        .sda_prev(line_prev[0]),
        .ev_valid(fr_valid),
        .ev_rec  (fr_rec),
        .trig    (trig_out)
    );

    i2cw_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (fr_valid),
        .in_rec   (fr_rec),
        .out_valid(evt_valid),
        .out_ready(evt_ready),
        .out_rec  (q_rec),
        .ovf      (ovf_flag),
        .ovf_clear(ovf_clear)
    );

    assign evt_kind = q_rec.kind;
    assign evt_data = q_rec.data;
    assign evt_ack  = q_rec.ack;
endmodule

// File: tb/i2c_bus_watcher_test.sv
module i2c_bus_watcher_test;
    localparam int DEPTH = 4;
    localparam int HOLD  = 3;
    localparam int Q     = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       evt_valid, evt_ready, evt_ack, trig_out, ovf_flag;
    logic       ovf_clear = 1'b0;
    logic [1:0] evt_kind;
    logic [7:0] evt_data;

    int n_checks = 0, n_fail = 0;
    int ready_mode = 1;
    logic [10:0] got [0:511];
    logic [10:0] exp_q [0:511];
    int n_got = 0, n_exp = 0;
    bit frame_open = 0, hold_mode = 0, exp_ovf = 0;
    int trig_run = 0, trig_pulses = 0, starts_exp = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_bus_watcher #(.DEPTH(DEPTH), .TRIG_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
        .evt_data(evt_data), .evt_ack(evt_ack), .trig_out(trig_out),
        .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
    );

    function automatic logic [10:0] mk(input logic [1:0] k, input logic [7:0] d, input logic a);
        return {k, d, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_push(input logic [10:0] r);
        if (hold_mode && n_exp >= DEPTH) exp_ovf = 1;
        else begin exp_q[n_exp] = r; n_exp++; end
    endtask

    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: evt_ready = 1'b0;
            1: evt_ready = 1'b1;
            default: evt_ready = 1'($urandom % 2);
        endcase
    end

    always @(negedge clk) begin
        if (rst_n && evt_valid && evt_ready) begin
            got[n_got] = {evt_kind, evt_data, evt_ack};
            n_got++;
        end
        if (trig_out) trig_run++;
        else if (trig_run > 0) begin
            check(trig_run == HOLD, "R6 trigger width", trig_run, HOLD);
            trig_pulses++;
            trig_run = 0;
        end
    end

    task automatic bus_start;
        sda = 1; tick(Q); scl = 1; tick(Q); sda = 0; tick(Q); scl = 0; tick(Q);
        exp_push(mk(frame_open ? 2'b01 : 2'b00, 8'h00, 1'b0));
        frame_open = 1;
        starts_exp++;
    endtask

    task automatic bus_bit(input logic b);
        sda = b; tick(Q); scl = 1; tick(2 * Q); scl = 0; tick(Q);
    endtask

    task automatic bus_byte(input logic [7:0] d, input logic a);
        for (int i = 7; i >= 0; i--) bus_bit(d[i]);
        bus_bit(a);
        if (frame_open) exp_push(mk(2'b11, d, a));
    endtask

    task automatic bus_stop;
        sda = 0; tick(Q); scl = 1; tick(Q); sda = 1; tick(2 * Q);
        exp_push(mk(2'b10, 8'h00, 1'b0));
        frame_open = 0;
    endtask

    task automatic compare(input string req);
        tick(30);
        check(n_got == n_exp, req, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            check(got[i] == exp_q[i], req, got[i], exp_q[i]);
        n_got = 0;
        n_exp = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        evt_ready = 1'b1;
        tick(5);
        check(evt_valid == 0, "R9 valid after reset", evt_valid, 0);
        check(trig_out == 0, "R9 trig after reset", trig_out, 0);
        check(ovf_flag == 0, "R9 ovf after reset", ovf_flag, 0);
        rst_n = 1;
        tick(10);

        // R1 R4 R3: plain write with ack and nack, unusual address
        bus_start; bus_byte(8'hA5, 1'b0); bus_byte(8'h3C, 1'b1); bus_stop;
        compare("R1/R4/R3 basic frame");

        // R3: SCL pulses after stop produce nothing
        scl = 0; tick(Q);
        for (int i = 0; i < 10; i++) bus_bit(1'($urandom % 2));
        sda = 1; tick(Q); scl = 1; tick(2 * Q);
        compare("R3 bits after stop ignored");

        // R2 R5: partial byte then repeated start
        bus_start; bus_bit(1); bus_bit(0); bus_bit(1);
        bus_start; bus_byte(8'h81, 1'b0); bus_stop;
        compare("R2/R5 repeated start mid-byte");

        // R2: repeated start on a byte boundary
        bus_start; bus_byte(8'hFF, 1'b0); bus_start; bus_byte(8'h00, 1'b1); bus_stop;
        compare("R2 repeated start at boundary");

        // random traffic with random ready (R4 R7)
        ready_mode = 2;
        for (int t = 0; t < 12; t++) begin
            int nb;
            bus_start;
            nb = 1 + int'($urandom % 3);
            for (int b = 0; b < nb; b++) bus_byte(8'($urandom), 1'($urandom % 2));
            if ($urandom % 3 == 0) begin
                int k;
                k = 1 + int'($urandom % 7);
                for (int j = 0; j < k; j++) bus_bit(1'($urandom % 2));
                bus_start;
                bus_byte(8'($urandom), 1'($urandom % 2));
            end
            bus_stop;
        end
        ready_mode = 1;
        compare("R4/R7 random traffic");

        // R7 R8: stall then overflow
        ready_mode = 0; hold_mode = 1; tick(2);
        bus_start; bus_byte(8'h5A, 1'b0); bus_byte(8'hC3, 1'b1); bus_stop;
        bus_start; bus_stop;
        check(evt_valid == 1, "R7 valid while stalled", evt_valid, 1);
        check({evt_kind, evt_data, evt_ack} == exp_q[0], "R7 head record held",
              {evt_kind, evt_data, evt_ack}, exp_q[0]);
        check(ovf_flag == exp_ovf, "R8 overflow set", ovf_flag, exp_ovf);
        hold_mode = 0; ready_mode = 1;
        compare("R7/R8 surviving records");
        check(ovf_flag == 1, "R8 overflow sticky", ovf_flag, 1);
        ovf_clear = 1; tick(1); ovf_clear = 0; tick(1);
        check(ovf_flag == 0, "R8 overflow cleared", ovf_flag, 0);

        tick(10);
        check(trig_pulses == starts_exp, "R6 trigger count", trig_pulses, starts_exp);
        check(trig_out == 0, "R6 trigger idle low", trig_out, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule